// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

A behavioural command controller for a parameterised x16 flash array split into an asymmetric set of erase blocks: a group of small parameter blocks and a group of large main blocks. A configuration input puts the parameter group at the low end or the high end of the address space. The host side is a chip-enable, output-enable and write-enable interface, sampled on the system clock. A command or data word is accepted on the rising edge of write enable while chip enable is low. A read presents data one clock after chip enable and output enable are both low.

Commands select the read mode (array, signature, status), clear the status flags, program one word or an aligned word pair, erase one block, and suspend or resume the running operation. Program and erase take a parameterised number of clock cycles. An erase that is suspended lets the host program other blocks. A program that is suspended allows reads only. A write-protect input, when low, locks two of the parameter blocks.

Command codes (low byte of the data bus): FFh read array, 90h signature, 70h status, 50h clear status, 40h program, 30h pair program, 20h erase setup, D0h erase confirm and resume, B0h suspend.

Top module: `bbf_ctrl`

## Requirements
- R1: After reset every word reads FFFFh in array mode, and the status word is 0080h. Status bit layout: [7] ready, [6] erase suspended, [5] erase fail, [4] program fail, [3] sequence error, [2] program suspended, [1] protection violation; bits 15..8 and 0 read 0.
- R2: An erase clears to FFFFh exactly the block that holds the confirm address and leaves every other block unchanged. With the parameter group at the bottom, blocks are ordered parameter blocks first. With it at the top, main blocks come first.
- R3: A program stores the bitwise AND of the old word and the new data. Ready reads 0 from the data write until PROG_CYC cycles have elapsed.
- R4: After 30h, two data writes program the word pair at the second write's address with bit 0 cleared and with bit 0 set. The first write supplies the even word and the second write the odd word.
- R5: With write protect low, program or erase on the two lowest blocks (bottom placement) or the two highest blocks (top placement) is refused. The data is unchanged, and status sets bit 1 plus bit 4 or bit 5. Other blocks, and any block with write protect high, are writable.
- R6: In signature mode an even address reads 0020h. An odd address reads 0090h with top placement and 0091h with bottom placement.
- R7: B0h during an erase suspends it (bit 6). A program to another block then completes. A program into the erasing block is refused with bit 4. D0h resumes the erase, which then completes. At most one operation advances at a time.
- R8: B0h during a program suspends it (bit 2). Reads work. Program or erase commands are rejected with bit 3. D0h resumes the program, which then completes.
- R9: An unknown command, or an erase setup not followed by D0h, sets bit 3 and selects array mode. Status flags persist until cleared.
- R10: Command 50h clears bits 1, 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low; accepted on its rising edge |
| top_cfg_i | input | 1 | 1: parameter blocks at top of address space |
| wp_ni | input | 1 | Write protect, active low |
| addr_i | input | AW | Word address |
| dq_i | input | DW | Command or data word |
| dq_o | output | DW | Read data |
| dq_oe_o | output | 1 | Read data valid (output driver enable) |

## Verification
The bench builds the block with 8 parameter blocks of 4 words and 4 main blocks of 8 words, which gives a 64-word array. In that array both placements produce different block boundaries at the same addresses: word 17 shares a block with word 20 only under top placement. Program and erase times of 8 and 24 cycles let a suspend command land while the operation is still running. They also leave room for a nested program to finish inside a suspended erase.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
  localparam logic [7:0] CMD_READ  = 8'hFF;
  localparam logic [7:0] CMD_SIG   = 8'h90;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_PAIR  = 8'h30;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;

  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_TOP  = 8'h90;
  localparam logic [7:0] DEV_BOT  = 8'h91;

  typedef enum logic [1:0] {RD_ARRAY, RD_SIG, RD_STAT} rd_mode_e;
  typedef enum logic [2:0] {CS_IDLE, CS_PDATA, CS_PAIR0, CS_PAIR1, CS_ECONF} cmd_st_e;
endpackage

// File: rtl/bbf_blk_map.sv
module bbf_blk_map #(
  parameter int N_PARAM = 8,
  parameter int N_MAIN  = 31,
  parameter int PW      = 4,
  parameter int MW      = 32,
  parameter int AW      = 10,
  parameter int BW      = 6
) (
  input  logic [AW-1:0] addr_i,
  input  logic          top_i,
  output logic [BW-1:0] id_o,
  output logic [AW-1:0] base_o,
  output logic [AW:0]   size_o,
  output logic          prot_o
);
  localparam int PSH = $clog2(PW);
  localparam int MSH = $clog2(MW);
  localparam logic [AW:0] PREG = (AW+1)'(N_PARAM * PW);
  localparam logic [AW:0] MREG = (AW+1)'(N_MAIN * MW);
  localparam logic [AW:0] PLO  = (AW+1)'(2);
  localparam logic [AW:0] PHI  = (AW+1)'(N_PARAM - 2);

  logic [AW:0] a_w, off, idx, base_w;
  logic        in_param;

  always_comb begin
    a_w      = {1'b0, addr_i};
    in_param = top_i ? (a_w >= MREG) : (a_w < PREG);
    off      = '0;
    if (!top_i) begin
      if (in_param) begin
        idx    = a_w >> PSH;
        base_w = idx << PSH;
        id_o   = BW'(idx);
      end else begin
        off    = a_w - PREG;
        idx    = off >> MSH;
        base_w = PREG + (idx << MSH);
        id_o   = BW'(idx + (AW+1)'(N_PARAM));
      end
    end else begin
      if (!in_param) begin
        idx    = a_w >> MSH;
        base_w = idx << MSH;
        id_o   = BW'(idx);
      end else begin
        off    = a_w - MREG;
        idx    = off >> PSH;
        base_w = MREG + (idx << PSH);
        id_o   = BW'(idx + (AW+1)'(N_MAIN));
      end
    end
    base_o = base_w[AW-1:0];
    size_o = in_param ? (AW+1)'(PW) : (AW+1)'(MW);
    prot_o = in_param && (top_i ? (idx >= PHI) : (idx < PLO));
  end
endmodule

// File: rtl/bbf_op_timer.sv
module bbf_op_timer #(
  parameter int CYC = 16,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= CW'(CYC);
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/bbf_array.sv
module bbf_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          pw_en_i,
  input  logic          pw_pair_i,
  input  logic [AW-1:0] pw_addr_i,
  input  logic [DW-1:0] pw_d0_i,
  input  logic [DW-1:0] pw_d1_i,
  input  logic          er_en_i,
  input  logic [AW-1:0] er_base_i,
  input  logic [AW:0]   er_size_i
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] er_hit, hit0, hit1;
  logic [AW-1:0]    a0, a1;
  logic [AW:0]      er_lo, er_hi;

  always_comb begin
    a0    = pw_pair_i ? {pw_addr_i[AW-1:1], 1'b0} : pw_addr_i;
    a1    = {pw_addr_i[AW-1:1], 1'b1};
    er_lo = {1'b0, er_base_i};
    er_hi = er_lo + er_size_i;
    for (int i = 0; i < DEPTH; i++) begin
      er_hit[i] = er_en_i && ((AW+1)'(i) >= er_lo) && ((AW+1)'(i) < er_hi);
      hit0[i]   = pw_en_i && (a0 == AW'(i));
      hit1[i]   = pw_en_i && pw_pair_i && (a1 == AW'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (er_hit[i])    mem_q[i] <= '1;
        else if (hit0[i]) mem_q[i] <= mem_q[i] & pw_d0_i;
        else if (hit1[i]) mem_q[i] <= mem_q[i] & pw_d1_i;
      end
    end
  end

  assign rd_data_o = ({1'b0, rd_addr_i} < (AW+1)'(DEPTH)) ? mem_q[rd_addr_i] : '1;
endmodule

// File: rtl/bbf_ctrl.sv
module bbf_ctrl
  import bbf_pkg::*;
#(
  parameter int N_PARAM   = 8,
  parameter int N_MAIN    = 31,
  parameter int PW        = 4,
  parameter int MW        = 32,
  parameter int DW        = 16,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  localparam int DEPTH    = N_PARAM * PW + N_MAIN * MW,
  localparam int AW       = $clog2(DEPTH),
  localparam int BW       = $clog2(N_PARAM + N_MAIN),
  localparam int ECW      = $clog2(ERASE_CYC + 1),
  localparam int PCW      = $clog2(PROG_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          top_cfg_i,
  input  logic          wp_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic          we_q, wr;
  logic [7:0]    cmd;
  cmd_st_e       st_q;
  rd_mode_e      mode_q;
  logic          efail_q, pfail_q, seq_q, protv_q;
  logic          prog_act, prog_sus, er_act, er_sus;
  logic [AW-1:0] p_addr, e_base;
  logic [AW:0]   e_size;
  logic [BW-1:0] e_id;
  logic [DW-1:0] p_d0, p_d1;
  logic          p_pair;
  logic [BW-1:0] blk_id;
  logic [AW-1:0] blk_base;
  logic [AW:0]   blk_size;
  logic          blk_prot;
  logic          prog_run, er_run, busy, p_done, e_done;
  logic          p_try, p_ref_prot, p_ref_conf, prog_start;
  logic          e_try, e_ref_prot, er_start, clr_hit;
  logic [ECW-1:0] e_cnt;
  logic [PCW-1:0] p_cnt;
  logic [DW-1:0] arr_rd, rd_val;
  logic [7:0]    sr;

  assign cmd      = dq_i[7:0];
  assign wr       = ~ce_ni & we_ni & ~we_q;
  assign prog_run = prog_act & ~prog_sus;
  assign er_run   = er_act & ~er_sus;
  assign busy     = prog_run | er_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  bbf_blk_map #(
    .N_PARAM(N_PARAM), .N_MAIN(N_MAIN), .PW(PW), .MW(MW), .AW(AW), .BW(BW)
  ) u_map (
    .addr_i(addr_i), .top_i(top_cfg_i), .id_o(blk_id), .base_o(blk_base),
    .size_o(blk_size), .prot_o(blk_prot)
  );

  assign p_try      = wr && (st_q == CS_PDATA || st_q == CS_PAIR1);
  assign p_ref_prot = p_try && !wp_ni && blk_prot;
  assign p_ref_conf = p_try && er_act && (blk_id == e_id);
  assign prog_start = p_try && !p_ref_prot && !p_ref_conf;
  assign e_try      = wr && (st_q == CS_ECONF) && (cmd == CMD_CONF);
  assign e_ref_prot = e_try && !wp_ni && blk_prot;
  assign er_start   = e_try && !e_ref_prot;
  assign clr_hit    = wr && (st_q == CS_IDLE) && !busy && (cmd == CMD_CLR);

  bbf_op_timer #(.CYC(PROG_CYC)) u_ptmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(prog_start), .run_i(prog_run),
    .done_o(p_done), .cnt_o(p_cnt)
  );

  bbf_op_timer #(.CYC(ERASE_CYC)) u_etmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(er_start), .run_i(er_run),
    .done_o(e_done), .cnt_o(e_cnt)
  );

  bbf_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_addr_i(addr_i), .rd_data_o(arr_rd),
    .pw_en_i(p_done), .pw_pair_i(p_pair), .pw_addr_i(p_addr), .pw_d0_i(p_d0),
    .pw_d1_i(p_d1), .er_en_i(e_done), .er_base_i(e_base), .er_size_i(e_size)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= CS_IDLE;  mode_q <= RD_ARRAY;
      efail_q <= 1'b0;  pfail_q <= 1'b0;  seq_q <= 1'b0;  protv_q <= 1'b0;
      prog_act <= 1'b0; prog_sus <= 1'b0; er_act <= 1'b0; er_sus <= 1'b0;
      p_addr <= '0; p_d0 <= '0; p_d1 <= '0; p_pair <= 1'b0;
      e_base <= '0; e_size <= '0; e_id <= '0;
    end else begin
      if (p_done) prog_act <= 1'b0;
      if (e_done) er_act <= 1'b0;
      if (wr) begin
        unique case (st_q)
          CS_PDATA, CS_PAIR1: begin
            st_q   <= CS_IDLE;
            mode_q <= RD_STAT;
            if (p_ref_prot) begin
              pfail_q <= 1'b1;
              protv_q <= 1'b1;
            end else if (p_ref_conf) begin
              pfail_q <= 1'b1;
            end else begin
              prog_act <= 1'b1;
              p_addr   <= addr_i;
              p_pair   <= (st_q == CS_PAIR1);
              if (st_q == CS_PAIR1) p_d1 <= dq_i;
              else                  p_d0 <= dq_i;
            end
          end
          CS_PAIR0: begin
            p_d0 <= dq_i;
            st_q <= CS_PAIR1;
          end
          CS_ECONF: begin
            st_q <= CS_IDLE;
            if (cmd != CMD_CONF) begin
              seq_q  <= 1'b1;
              mode_q <= RD_ARRAY;
            end else begin
              mode_q <= RD_STAT;
              if (e_ref_prot) begin
                efail_q <= 1'b1;
                protv_q <= 1'b1;
              end else begin
                er_act <= 1'b1;
                e_base <= blk_base;
                e_size <= blk_size;
                e_id   <= blk_id;
              end
            end
          end
          default: begin
            if (busy) begin
              if (cmd == CMD_SUSP) begin
                if (prog_run && !er_sus) begin
                  prog_sus <= 1'b1;
                  mode_q   <= RD_STAT;
                end else if (er_run) begin
                  er_sus <= 1'b1;
                  mode_q <= RD_STAT;
                end
              end else if (cmd == CMD_STAT) begin
                mode_q <= RD_STAT;
              end
            end else begin
              unique case (cmd)
                CMD_READ: mode_q <= RD_ARRAY;
                CMD_SIG:  mode_q <= RD_SIG;
                CMD_STAT: mode_q <= RD_STAT;
                CMD_CLR: begin
                  efail_q <= 1'b0; pfail_q <= 1'b0; seq_q <= 1'b0; protv_q <= 1'b0;
                end
                CMD_PROG, CMD_PAIR: begin
                  if (prog_sus) begin
                    seq_q  <= 1'b1;
                    mode_q <= RD_ARRAY;
                  end else begin
                    st_q <= (cmd == CMD_PROG) ? CS_PDATA : CS_PAIR0;
                  end
                end
                CMD_ERASE: begin
                  if (prog_sus || er_act) begin
                    seq_q  <= 1'b1;
                    mode_q <= RD_ARRAY;
                  end else begin
                    st_q <= CS_ECONF;
                  end
                end
                CMD_CONF: begin
                  if (prog_sus) begin
                    prog_sus <= 1'b0;
                    mode_q   <= RD_STAT;
                  end else if (er_sus) begin
                    er_sus <= 1'b0;
                    mode_q <= RD_STAT;
                  end else begin
                    seq_q  <= 1'b1;
                    mode_q <= RD_ARRAY;
                  end
                end
                CMD_SUSP: ;
                default: begin
                  seq_q  <= 1'b1;
                  mode_q <= RD_ARRAY;
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  assign sr = {~busy, er_sus, efail_q, pfail_q, seq_q, prog_sus, protv_q, 1'b0};

  always_comb begin
    unique case (mode_q)
      RD_SIG:  rd_val = addr_i[0] ? DW'(top_cfg_i ? DEV_TOP : DEV_BOT) : DW'(MFR_CODE);
      RD_STAT: rd_val = DW'(sr);
      default: rd_val = arr_rd;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      dq_o    <= rd_val;
      dq_oe_o <= ~ce_ni & ~oe_ni;
    end
  end
endmodule

// File: rtl/bbf_ctrl_chk.sv
module bbf_ctrl_chk #(
  parameter int ECW = 7,
  parameter int PCW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           prog_run,
  input logic           er_run,
  input logic           er_sus,
  input logic           prog_sus,
  input logic           er_act,
  input logic [ECW-1:0] e_cnt,
  input logic [PCW-1:0] p_cnt,
  input logic [7:0]     sr,
  input logic           p_ref_prot,
  input logic           clr_hit
);
  // R7
  one_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_run, er_run}));

  // R7
  erase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (er_sus && $past(er_sus)) |-> $stable(e_cnt));

  // R8
  prog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_sus && $past(prog_sus)) |-> ($stable(p_cnt) && $stable(er_act)));

  // R5
  prot_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_ref_prot |=> (sr[1] && sr[4]));

  // R9
  seq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr[3] && !clr_hit) |=> sr[3]);
endmodule

bind bbf_ctrl bbf_ctrl_chk #(.ECW(ECW), .PCW(PCW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prog_run(prog_run), .er_run(er_run),
  .er_sus(er_sus), .prog_sus(prog_sus), .er_act(er_act), .e_cnt(e_cnt),
  .p_cnt(p_cnt), .sr(sr), .p_ref_prot(p_ref_prot), .clr_hit(clr_hit)
);

// File: tb/tb_bbf_ctrl.sv
module tb_bbf_ctrl;
  localparam int N_PARAM = 8, N_MAIN = 4, PW = 4, MW = 8;
  localparam int PROG_CYC = 8, ERASE_CYC = 24;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, top_cfg = 1'b0, wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq = '0, dq_o;
  logic dq_oe;

  always #5 clk = ~clk;

  bbf_ctrl #(
    .N_PARAM(N_PARAM), .N_MAIN(N_MAIN), .PW(PW), .MW(MW), .DW(16),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .top_cfg_i(top_cfg), .wp_ni(wp_n), .addr_i(addr), .dq_i(dq),
    .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  smp_ev;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  // monitor: pops expected item when the driver marks a sample point
  initial begin
    item_t it;
    forever begin
      @(smp_ev);
      it = sb.pop_front();
      checks++;
      if (dq_o !== it.exp || dq_oe !== 1'b1) begin
        errors++;
        $display("FAIL %s: got %h (oe %b) exp %h", it.tag, dq_o, dq_oe, it.exp);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; dq = d;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    @(negedge clk);
    sb.push_back('{exp, tag});
    ->smp_ev;
    #1;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    wr(a, 16'h0040); wr(a, d); idle(PROG_CYC + 6); wr(a, 16'h00FF);
  endtask

  task automatic erase(input logic [AW-1:0] a);
    wr(a, 16'h0020); wr(a, 16'h00D0); idle(ERASE_CYC + 6); wr(a, 16'h00FF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1
    rd(5, 16'hFFFF, "R1 erased after reset");
    wr(0, 16'h0070);
    rd(0, 16'h0080, "R1 status after reset");
    wr(0, 16'h00FF);
    // R3
    wr(40, 16'h0040); wr(40, 16'hF0F0);
    rd(40, 16'h0000, "R3 busy during program");
    idle(12);
    rd(40, 16'h0080, "R3 ready after program");
    wr(0, 16'h00FF);
    rd(40, 16'hF0F0, "R3 programmed word");
    prog(40, 16'h3CFF);
    rd(40, 16'h30F0, "R3 AND of old and new");
    // R4
    wr(45, 16'h0030); wr(45, 16'h1234); wr(45, 16'hABCD);
    idle(PROG_CYC + 6); wr(0, 16'h00FF);
    rd(44, 16'h1234, "R4 even word");
    rd(45, 16'hABCD, "R4 odd word");
    rd(46, 16'hFFFF, "R4 next word untouched");
    // R2 bottom placement
    prog(36, 16'h0000); prog(31, 16'h0001);
    erase(34);
    rd(36, 16'hFFFF, "R2 erased block");
    rd(31, 16'h0001, "R2 neighbour param block");
    rd(40, 16'h30F0, "R2 neighbour main block");
    // R5
    wp_n = 1'b0;
    wr(2, 16'h0040); wr(2, 16'h0000);
    rd(0, 16'h0092, "R5 program refused");
    wr(0, 16'h00FF);
    rd(2, 16'hFFFF, "R5 protected data kept");
    // R10
    wr(0, 16'h0050); wr(0, 16'h0070);
    rd(0, 16'h0080, "R10 flags cleared");
    prog(9, 16'h5555);
    rd(9, 16'h5555, "R5 unprotected block writable");
    wr(1, 16'h0020); wr(1, 16'h00D0);
    rd(0, 16'h00A2, "R5 erase refused");
    wr(0, 16'h0050);
    wp_n = 1'b1;
    prog(2, 16'h0F0F);
    rd(2, 16'h0F0F, "R5 writable with protect high");
    // R9
    wr(0, 16'h0077);
    rd(9, 16'h5555, "R9 array mode after bad command");
    wr(0, 16'h0070);
    rd(0, 16'h0088, "R9 sequence error");
    wr(0, 16'h0050);
    wr(0, 16'h0020); wr(0, 16'h00FF);
    rd(9, 16'h5555, "R9 array mode after bad confirm");
    wr(0, 16'h0070);
    rd(0, 16'h0088, "R9 missing confirm");
    wr(0, 16'h0050);
    // R6
    wr(0, 16'h0090);
    rd(0, 16'h0020, "R6 manufacturer code");
    rd(1, 16'h0091, "R6 bottom device code");
    wr(0, 16'h00FF);
    // R8
    wr(48, 16'h0040); wr(48, 16'h00FF); wr(0, 16'h00B0);
    rd(0, 16'h0084, "R8 program suspended");
    wr(0, 16'h00FF);
    rd(9, 16'h5555, "R8 read during suspend");
    rd(48, 16'hFFFF, "R8 program not applied yet");
    wr(0, 16'h0020); wr(0, 16'h0070);
    rd(0, 16'h008C, "R8 erase rejected");
    wr(0, 16'h00D0);
    idle(PROG_CYC + 6);
    rd(0, 16'h0088, "R8 resumed and finished");
    wr(0, 16'h00FF);
    rd(48, 16'h00FF, "R8 resumed program applied");
    wr(0, 16'h0050);
    // R7
    prog(56, 16'h0000); prog(60, 16'h1111);
    wr(56, 16'h0020); wr(56, 16'h00D0); wr(0, 16'h00B0);
    rd(0, 16'h00C0, "R7 erase suspended");
    wr(60, 16'h0040); wr(60, 16'h0000);
    rd(0, 16'h00D0, "R7 program into erasing block refused");
    wr(50, 16'h0040); wr(50, 16'h0F00);
    idle(PROG_CYC + 6);
    rd(0, 16'h00D0, "R7 nested program finished");
    wr(0, 16'h00FF);
    rd(50, 16'h0F00, "R7 other block programmed");
    rd(56, 16'h0000, "R7 erase held");
    wr(0, 16'h00D0);
    idle(ERASE_CYC + 6);
    wr(0, 16'h00FF);
    rd(56, 16'hFFFF, "R7 resumed erase done");
    rd(60, 16'hFFFF, "R7 whole block erased");
    wr(0, 16'h0050);
    // top placement
    top_cfg = 1'b1;
    wr(0, 16'h0090);
    rd(1, 16'h0090, "R6 top device code");
    wr(0, 16'h00FF);
    wp_n = 1'b0;
    wr(60, 16'h0040); wr(60, 16'h0000);
    rd(0, 16'h0092, "R5 top protected block refused");
    wr(0, 16'h0050); wr(0, 16'h00FF);
    rd(60, 16'hFFFF, "R5 top protected data kept");
    prog(50, 16'h00F0);
    rd(50, 16'h0000, "R5 top unprotected param block");
    wp_n = 1'b1;
    prog(17, 16'h0000); prog(24, 16'h0000);
    erase(20);
    rd(17, 16'hFFFF, "R2 top main block erased");
    rd(24, 16'h0000, "R2 top neighbour kept");
    done = 1'b1;
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule